// File: doc/BRIEF.md
# Tick Compare Interrupt Unit

This unit keeps the privileged timer state of a processor core. It has a 64-bit tick counter that advances every clock, a supervisor compare register and a hypervisor compare register, and a soft-interrupt pending register. When the counter reaches an enabled compare value, the unit raises an interrupt request. A supervisor match also sets a fixed pending flag in the soft-interrupt register. A hypervisor match raises its own request line instead.

Software reaches the state through one register port, selected by a 3-bit index. A write to the soft-interrupt register can take one of three forms: a direct load, an OR-in through a set index, or a mask-out through a clear index. The recheck output tells the trap logic that the interrupt picture may have changed.

Each compare register is handled by a channel state machine with three states:
- CH_OFF: the compare is disabled by its top bit.
- CH_WAIT: the compare is enabled and waiting.
- CH_HIT: the one cycle after a match.

The transitions are:
- enable, from CH_OFF to CH_WAIT.
- match, from CH_OFF, CH_WAIT or CH_HIT to CH_HIT.
- rearm, from CH_HIT back to CH_WAIT.
- disable, from any state to CH_OFF.

Each transition is evaluated on every clock from the registered compare and counter values.

Top module: `tick_cmp_unit`

## Requirements
- R1: Index 0 is the counter. With no write to index 0, bits 62:0 increase by one each clock and wrap to zero after all ones, and bit 63 holds its value. A write to index 0 loads all 64 bits, and the new value is read back on the next cycle.
- R2: A write to index 1 loads the soft-interrupt register with the write data. In the next cycle soft_irq_o is high for one cycle.
- R3: A write to index 2 makes the soft-interrupt register equal to its old value OR the write data.
- R4: A write to index 3 makes the soft-interrupt register equal to its old value AND the inverse of the write data.
- R5: Index 4 is the supervisor compare and index 5 is the hypervisor compare. Each compares only its bits 62:0 against counter bits 62:0. While its bit 63 is set, a compare never fires.
- R6: Suppose that in some cycle the supervisor compare is enabled and equals the counter. Then in the next cycle bit 16 of the soft-interrupt register is set and soft_irq_o is high.
- R7: Suppose that in some cycle the hypervisor compare is enabled and equals the counter. Then in the next cycle hyp_irq_o is high for one cycle, and bit 16 of the soft-interrupt register is not touched by the match.
- R8: A compare value written strictly ahead of the count in the write cycle fires when the counter reaches it. A value equal to or behind that count does not fire before the counter wraps.
- R9: recheck_o is high for one cycle after any match, and after any write to index 1, 2 or 3. Otherwise it is low.
- R10: After reset the counter and the soft-interrupt register are zero. Both compare registers hold only bit 63 set. All three outputs are low.
- R11: Reads at index 2 or 3 return the soft-interrupt register. Indices 6 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_idx_i | input | 3 | Register index |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for reg_idx_i, combinational from the current state |
| soft_irq_o | output | 1 | Soft-interrupt request pulse |
| hyp_irq_o | output | 1 | Hypervisor compare match request pulse |
| recheck_o | output | 1 | Pulse telling the trap logic to re-evaluate interrupts |

## Verification
The assertions assume the register index and write data are stable and known at every clock edge while reset is released, and that only one register access happens per cycle. The stimulus meets this by changing inputs only on the falling clock edge. Random compare values are drawn within a few counts of the current counter, so matches are frequent. The top bit is set on about a quarter of the writes, so disabled compares are exercised as well. Counter loads include values just below the 63-bit wrap, so the wrap is covered.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
    localparam int unsigned IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_COUNT    = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SOFT     = 3'd1;
    localparam logic [IDX_W-1:0] IDX_SOFT_SET = 3'd2;
    localparam logic [IDX_W-1:0] IDX_SOFT_CLR = 3'd3;
    localparam logic [IDX_W-1:0] IDX_SUP_CMP  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_HYP_CMP  = 3'd5;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_HIT  = 2'd2
    } ch_state_t;

    typedef enum logic [1:0] {
        SW_NONE = 2'd0,
        SW_LOAD = 2'd1,
        SW_SET  = 2'd2,
        SW_CLR  = 2'd3
    } soft_op_t;
endpackage

// File: rtl/tcu_counter.sv
module tcu_counter #(
    parameter int unsigned W = 64
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    // The top bit is a plain stored bit; only the low W-1 bits count.
    always_comb begin
        if (ld_i) cnt_d = ld_val_i;
        else      cnt_d = {cnt_q[W-1], cnt_q[W-2:0] + 1'b1};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tcu_cmp_chan.sv
module tcu_cmp_chan
    import tcu_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] cmp_o,
    output logic         fire_o,
    output logic         hit_o
);
    localparam logic [W-1:0] RST_VAL = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] cmp_q;
    ch_state_t    state_q, state_d;
    logic         off_now;
    logic         eq_now;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cmp_q <= RST_VAL;
        else if (wr_i) cmp_q <= wdata_i;
    end

    assign off_now = cmp_q[W-1];
    assign eq_now  = (cmp_q[W-2:0] == cnt_i[W-2:0]);
    assign fire_o  = !off_now && eq_now;

    // Next-state logic: enable, match, rearm, disable.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (fire_o)        state_d = CH_HIT;   // match
                else if (!off_now) state_d = CH_WAIT;  // enable
            end
            CH_WAIT: begin
                if (off_now)       state_d = CH_OFF;   // disable
                else if (eq_now)   state_d = CH_HIT;   // match
            end
            CH_HIT: begin
                if (off_now)       state_d = CH_OFF;   // disable
                else if (eq_now)   state_d = CH_HIT;   // match again
                else               state_d = CH_WAIT;  // rearm
            end
            default:               state_d = CH_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CH_OFF;
        else         state_q <= state_d;
    end

    // Output logic.
    always_comb begin
        hit_o = (state_q == CH_HIT);
    end

    assign cmp_o = cmp_q;
endmodule

// File: rtl/tcu_softint.sv
module tcu_softint
    import tcu_pkg::*;
#(
    parameter int unsigned W        = 64,
    parameter int unsigned FLAG_BIT = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  soft_op_t     op_i,
    input  logic [W-1:0] wdata_i,
    input  logic         tick_set_i,
    output logic [W-1:0] pend_o
);
    localparam logic [W-1:0] FLAG_MASK = {{(W-1){1'b0}}, 1'b1} << FLAG_BIT;

    logic [W-1:0] pend_q;
    logic [W-1:0] base;
    logic [W-1:0] pend_d;

    always_comb begin
        unique case (op_i)
            SW_LOAD: base = wdata_i;
            SW_SET:  base = pend_q | wdata_i;
            SW_CLR:  base = pend_q & ~wdata_i;
            default: base = pend_q;
        endcase
        // A match in the same cycle as a write still leaves the flag set.
        pend_d = tick_set_i ? (base | FLAG_MASK) : base;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit
    import tcu_pkg::*;
#(
    parameter int unsigned W        = 64,
    parameter int unsigned FLAG_BIT = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_wr_i,
    input  logic [IDX_W-1:0]     reg_idx_i,
    input  logic [W-1:0]         reg_wdata_i,
    output logic [W-1:0]         reg_rdata_o,
    output logic                 soft_irq_o,
    output logic                 hyp_irq_o,
    output logic                 recheck_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] soft_q;
    logic [W-1:0] sup_cmp;
    logic [W-1:0] hyp_cmp;
    logic         sup_fire, hyp_fire;
    logic         sup_hit, hyp_hit;
    logic         cnt_wr, sup_wr, hyp_wr;
    soft_op_t     soft_op;
    logic         load_q, swr_q;

    // Write decode.
    assign cnt_wr = reg_wr_i && (reg_idx_i == IDX_COUNT);
    assign sup_wr = reg_wr_i && (reg_idx_i == IDX_SUP_CMP);
    assign hyp_wr = reg_wr_i && (reg_idx_i == IDX_HYP_CMP);

    always_comb begin
        soft_op = SW_NONE;
        if (reg_wr_i) begin
            unique case (reg_idx_i)
                IDX_SOFT:     soft_op = SW_LOAD;
                IDX_SOFT_SET: soft_op = SW_SET;
                IDX_SOFT_CLR: soft_op = SW_CLR;
                default:      soft_op = SW_NONE;
            endcase
        end
    end

    tcu_counter #(.W(W)) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ld_i     (cnt_wr),
        .ld_val_i (reg_wdata_i),
        .cnt_o    (cnt_q)
    );

    tcu_cmp_chan #(.W(W)) u_sup (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (sup_wr),
        .wdata_i (reg_wdata_i),
        .cnt_i   (cnt_q),
        .cmp_o   (sup_cmp),
        .fire_o  (sup_fire),
        .hit_o   (sup_hit)
    );

    tcu_cmp_chan #(.W(W)) u_hyp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (hyp_wr),
        .wdata_i (reg_wdata_i),
        .cnt_i   (cnt_q),
        .cmp_o   (hyp_cmp),
        .fire_o  (hyp_fire),
        .hit_o   (hyp_hit)
    );

    tcu_softint #(.W(W), .FLAG_BIT(FLAG_BIT)) u_soft (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .op_i       (soft_op),
        .wdata_i    (reg_wdata_i),
        .tick_set_i (sup_fire),
        .pend_o     (soft_q)
    );

    // One-cycle markers of soft-interrupt writes.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            load_q <= 1'b0;
            swr_q  <= 1'b0;
        end else begin
            load_q <= (soft_op == SW_LOAD);
            swr_q  <= (soft_op != SW_NONE);
        end
    end

    assign soft_irq_o = sup_hit || load_q;
    assign hyp_irq_o  = hyp_hit;
    assign recheck_o  = sup_hit || hyp_hit || swr_q;

    // Read mux.
    always_comb begin
        unique case (reg_idx_i)
            IDX_COUNT:                       reg_rdata_o = cnt_q;
            IDX_SOFT, IDX_SOFT_SET,
            IDX_SOFT_CLR:                    reg_rdata_o = soft_q;
            IDX_SUP_CMP:                     reg_rdata_o = sup_cmp;
            IDX_HYP_CMP:                     reg_rdata_o = hyp_cmp;
            default:                         reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/tcu_chk.sv
module tcu_chk #(
    parameter int unsigned W        = 64,
    parameter int unsigned FLAG_BIT = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         reg_wr_i,
    input logic [2:0]   reg_idx_i,
    input logic [W-1:0] reg_wdata_i,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] soft_q,
    input logic [W-1:0] sup_cmp,
    input logic [W-1:0] hyp_cmp,
    input logic         soft_irq_o,
    input logic         hyp_irq_o,
    input logic         recheck_o
);
    localparam logic [W-1:0] FLAG_MASK = {{(W-1){1'b0}}, 1'b1} << FLAG_BIT;

    logic past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && !$past(reg_wr_i && reg_idx_i == 3'd0)) |->
        (cnt_q[W-2:0] == $past(cnt_q[W-2:0]) + 1'b1) && (cnt_q[W-1] == $past(cnt_q[W-1]))); // R1

    AST_SET_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(reg_wr_i && reg_idx_i == 3'd2)) |->
        ((soft_q | FLAG_MASK) == ($past(soft_q) | $past(reg_wdata_i) | FLAG_MASK))); // R3

    AST_CLR_ANDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(reg_wr_i && reg_idx_i == 3'd3)) |->
        ((soft_q | FLAG_MASK) == (($past(soft_q) & ~$past(reg_wdata_i)) | FLAG_MASK))); // R4

    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && hyp_irq_o) |-> !$past(hyp_cmp[W-1])); // R5

    AST_SUP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(!sup_cmp[W-1] && sup_cmp[W-2:0] == cnt_q[W-2:0])) |->
        (soft_q[FLAG_BIT] && soft_irq_o)); // R6

    AST_HYP_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && hyp_irq_o) |-> ($past(hyp_cmp[W-2:0]) == $past(cnt_q[W-2:0]))); // R7

    AST_RECHECK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && recheck_o) |->
        ($past(reg_wr_i && reg_idx_i >= 3'd1 && reg_idx_i <= 3'd3) ||
         $past(!sup_cmp[W-1] && sup_cmp[W-2:0] == cnt_q[W-2:0]) ||
         $past(!hyp_cmp[W-1] && hyp_cmp[W-2:0] == cnt_q[W-2:0]))); // R9
endmodule

bind tick_cmp_unit tcu_chk #(.W(W), .FLAG_BIT(FLAG_BIT)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wdata_i (reg_wdata_i),
    .cnt_q       (cnt_q),
    .soft_q      (soft_q),
    .sup_cmp     (sup_cmp),
    .hyp_cmp     (hyp_cmp),
    .soft_irq_o  (soft_irq_o),
    .hyp_irq_o   (hyp_irq_o),
    .recheck_o   (recheck_o)
);

// File: tb/tick_cmp_unit_tb.sv
module tick_cmp_unit_tb;
    localparam logic [63:0] TOP  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] FLAG = 64'h0000_0000_0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  idx = 3'd0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        soft_irq, hyp_irq, recheck;

    int unsigned vectors = 0;
    int unsigned fails = 0;
    bit          done = 1'b0;

    // Reference state.
    logic [63:0] m_cnt, m_soft, m_scmp, m_hcmp;
    logic        m_sirq, m_hirq, m_rchk;

    always #5 clk = ~clk;

    tick_cmp_unit u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (wr),
        .reg_idx_i   (idx),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .soft_irq_o  (soft_irq),
        .hyp_irq_o   (hyp_irq),
        .recheck_o   (recheck)
    );

    function automatic logic sup_match(logic [63:0] c, logic [63:0] k);
        return !k[63] && (k[62:0] == c[62:0]);
    endfunction

    function automatic logic [63:0] exp_rd(logic [2:0] i);
        case (i)
            3'd0:             return m_cnt;
            3'd1, 3'd2, 3'd3: return m_soft;
            3'd4:             return m_scmp;
            3'd5:             return m_hcmp;
            default:          return 64'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_soft = '0; m_scmp = TOP; m_hcmp = TOP;
            m_sirq = 0; m_hirq = 0; m_rchk = 0;
        end else begin
            logic fs, fh;
            logic [63:0] ns;
            fs = sup_match(m_cnt, m_scmp);
            fh = sup_match(m_cnt, m_hcmp);
            ns = m_soft;
            if (wr && idx == 3'd1) ns = wdata;
            if (wr && idx == 3'd2) ns = m_soft | wdata;
            if (wr && idx == 3'd3) ns = m_soft & ~wdata;
            if (fs) ns = ns | FLAG;
            m_sirq = (wr && idx == 3'd1) || fs;
            m_hirq = fh;
            m_rchk = fs || fh || (wr && idx >= 3'd1 && idx <= 3'd3);
            m_soft = ns;
            if (wr && idx == 3'd0) m_cnt = wdata;
            else m_cnt = {m_cnt[63], m_cnt[62:0] + 63'd1};
            if (wr && idx == 3'd4) m_scmp = wdata;
            if (wr && idx == 3'd5) m_hcmp = wdata;
        end
    end

    task automatic check_all(string tag);
        logic [63:0] er;
        er = exp_rd(idx);
        vectors++;
        if (rdata !== er || soft_irq !== m_sirq || hyp_irq !== m_hirq || recheck !== m_rchk) begin
            fails++;
            $display("FAIL %s idx=%0d rdata=%h/%h soft=%b/%b hyp=%b/%b rchk=%b/%b (actual/expected)",
                     tag, idx, rdata, er, soft_irq, m_sirq, hyp_irq, m_hirq, recheck, m_rchk);
        end
    endtask

    task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of input at the falling edge, then check at the next falling edge.
    task automatic cyc(logic w, logic [2:0] i, logic [63:0] d, string tag);
        wr = w; idx = i; wdata = d;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(int n, logic [2:0] i, string tag);
        for (int k = 0; k < n; k++) cyc(1'b0, i, 64'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [2:0]  ri;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state before any clock out of reset
        chk64("R10 count", rdata, 64'd0);
        idx = 3'd4; #1 chk64("R10 sup cmp", rdata, TOP);
        idx = 3'd5; #1 chk64("R10 hyp cmp", rdata, TOP);
        idx = 3'd1; #1 chk64("R10 soft", rdata, 64'd0);
        chk64("R10 outputs", {61'd0, soft_irq, hyp_irq, recheck}, 64'd0);
        idx = 3'd0;
        idle(3, 3'd0, "R1");
        chk64("R1 count runs", rdata, 64'd3);
        // R1: load with top bit, then wrap
        cyc(1'b1, 3'd0, TOP | 64'h10, "R1");
        chk64("R1 load readback", rdata, TOP | 64'h10);
        idle(2, 3'd0, "R1");
        chk64("R1 top bit held", rdata, TOP | 64'h12);
        cyc(1'b1, 3'd0, 64'h7FFF_FFFF_FFFF_FFFE, "R1");
        idle(2, 3'd0, "R1");
        chk64("R1 wrap", rdata, 64'd0);
        // R2 / R3 / R4 / R11
        cyc(1'b1, 3'd1, 64'h00A5_0000_0000_00A5, "R2");
        chk64("R2 irq pulse", {63'd0, soft_irq}, 64'd1);
        idle(1, 3'd1, "R2");
        chk64("R2 single pulse", {63'd0, soft_irq}, 64'd0);
        cyc(1'b1, 3'd2, 64'h0F00, "R3");
        chk64("R3 set alias", rdata, 64'h00A5_0000_0000_0FA5);
        cyc(1'b1, 3'd3, 64'h00A0_0000_0000_0005, "R4");
        chk64("R4 clear alias", rdata, 64'h0005_0000_0000_0FA0);
        chk64("R9 recheck on alias", {63'd0, recheck}, 64'd1);
        cyc(1'b1, 3'd6, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
        chk64("R11 idx6 reads zero", rdata, 64'd0);
        cyc(1'b0, 3'd3, 64'd0, "R11");
        chk64("R11 idx3 reads soft", rdata, 64'h0005_0000_0000_0FA0);
        cyc(1'b0, 3'd4, 64'd0, "R11");
        chk64("R11 idx6 write ignored", rdata, TOP);
        // R6 supervisor match
        cyc(1'b1, 3'd1, 64'd0, "R6");
        cyc(1'b1, 3'd4, m_cnt + 64'd4, "R6");
        idle(6, 3'd1, "R6");
        chk64("R6 flag set", rdata & FLAG, FLAG);
        // R7 hypervisor match, no flag
        cyc(1'b1, 3'd1, 64'd0, "R7");
        cyc(1'b1, 3'd5, m_cnt + 64'd3, "R7");
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 3'd1, 64'd0, "R7");
            if (hyp_irq) chk64("R7 no flag", rdata & FLAG, 64'd0);
        end
        // R5 disabled compare with matching low bits
        cyc(1'b1, 3'd5, TOP | (m_cnt + 64'd3), "R5");
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 3'd1, 64'd0, "R5");
            chk64("R5 disabled quiet", {63'd0, hyp_irq}, 64'd0);
        end
        // R8 equal-to-count does not fire; one ahead fires
        cyc(1'b1, 3'd4, m_cnt, "R8");
        for (int k = 0; k < 8; k++) begin
            cyc(1'b0, 3'd1, 64'd0, "R8");
            chk64("R8 behind quiet", {63'd0, soft_irq}, 64'd0);
        end
        cyc(1'b1, 3'd4, m_cnt + 64'd1, "R8");
        cyc(1'b0, 3'd1, 64'd0, "R8");
        chk64("R8 ahead fires", {62'd0, soft_irq, recheck}, 64'd3);
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            ri = 3'($urandom_range(0, 7));
            d  = {$urandom, $urandom};
            if (ri == 3'd4 || ri == 3'd5) begin
                d = m_cnt + 64'($urandom_range(0, 8));
                d[63] = ($urandom_range(0, 3) == 0);
            end else if (ri == 3'd0 && $urandom_range(0, 1) == 0) begin
                d = 64'h7FFF_FFFF_FFFF_FFF0 + 64'($urandom_range(0, 15));
            end
            cyc(($urandom_range(0, 9) < 3), ri, d, "RND R2 R3 R4 R6 R7 R9");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule